// File: doc/BRIEF.md
# Parallel Video to Ping-Pong Buffer Packer

This block receives a parallel pixel stream. Each sample is qualified by a frame-valid and a line-valid strobe. The block packs the accepted samples into two fixed-size packet buffers and fills them in turn. The buffer storage sits outside the block. The packer drives a write port (buffer select, word address, data) into that storage and never holds pixel data itself. The pixel bus and both strobes are captured on the falling edge of the pixel clock. All other logic runs on the rising edge of the same clock.

A buffer is handed to the downstream consumer in one of two cases. The first is when it holds `BUF_WORDS` words, which is a full commit. The second is when frame-valid drops, which is a short end-of-frame commit carrying the actual byte count. After either commit the packer continues in the other buffer. A handed-over buffer stays with the consumer until the consumer returns it with a release pulse that names it.

A sample can arrive while the active buffer is still held by the consumer. That sample is discarded and a sticky overrun flag is raised. Frame tracking keeps running during an overrun, so the packer recovers cleanly at the next frame start once buffers are returned. With the default parameters (16-bit bus, 8184-word buffers) a 614400-byte frame leaves as 37 full 16368-byte buffers followed by an 8784-byte end-of-frame buffer.

Top module: `vpk_packer`

## Requirements
- R1: A sample is accepted only if, at a falling clock edge, both frame-valid and line-valid are high and a frame is in progress. Every accepted sample's data reaches `wr_data` unchanged. Bus values during line blanking, or while frame-valid is low, produce no write.
- R2: Within one buffer, the accepted samples of a frame are written in arrival order at word addresses 0, 1, 2 and so on. The first frame after reset writes buffer 0.
- R3: The write that fills word `BUF_WORDS-1` is accompanied in the same cycle by a commit of that buffer. The commit carries `done_bytes` = `BUF_WORDS*DATA_W/8` (16368 for the defaults) and `done_eof` = 0. The next accepted sample goes to address 0 of the other buffer.
- R4: When frame-valid falls and the active buffer holds k > 0 words, the packer commits it with `done_bytes` = k*`DATA_W`/8 and `done_eof` = 1. The next frame starts in the other buffer.
- R5: When frame-valid falls and the active buffer holds no words, the packer emits an end marker with `done_bytes` = 0 and `done_eof` = 1. The buffer is not handed over, and the next frame starts in that same buffer.
- R6: A buffer committed with a nonzero byte count stays held until a `rel` pulse arrives with `rel_sel` naming it. A release naming the other buffer leaves it held. A sample that falls to a held buffer produces no write, does not advance the word count, and sets `overrun`.
- R7: `overrun` remains set until `ovf_clr` is pulsed. A pulse of `ovf_clr` with no overrun in the same cycle clears the flag.
- R8: Reset clears `wr_en`, `done_valid` and `overrun`. After reset the packer waits for a rising edge of frame-valid, so a frame already in progress when reset is released produces no write and no commit.
- R9: After an overrun, once the held buffers are released, the next frame is written from address 0 of the selected buffer with correct data and byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; the bus is captured on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_data | input | DATA_W | Parallel pixel bus |
| frame_vld | input | 1 | Frame-valid strobe |
| line_vld | input | 1 | Line-valid strobe |
| ovf_clr | input | 1 | Clears the sticky overrun flag |
| rel | input | 1 | Consumer release pulse |
| rel_sel | input | 1 | Buffer returned by `rel` |
| wr_en | output | 1 | Write strobe to buffer storage |
| wr_sel | output | 1 | Buffer being written |
| wr_addr | output | clog2(BUF_WORDS) | Word address within the buffer |
| wr_data | output | DATA_W | Word to store |
| done_valid | output | 1 | One-cycle commit or end-marker pulse |
| done_sel | output | 1 | Buffer the commit refers to |
| done_bytes | output | clog2(BUF_WORDS*DATA_W/8+1) | Byte count of the committed buffer |
| done_eof | output | 1 | Commit closes a frame |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach is the one where both buffers are held by the consumer while pixels keep arriving. Reaching it needs a frame longer than two buffers and a consumer that stops returning buffers. The bench switches off its automatic consumer and sends a 2.5-buffer frame. It then issues a release for the wrong buffer, then for the right one, and checks that writing resumes cleanly at address 0. A sweep of frame lengths that crosses every buffer multiple drives the exact-boundary case, in which frame end finds an empty buffer.

// File: rtl/vpk_pkg.sv
package vpk_pkg;

   // Number of alternating buffers; the select is a single bit.
   localparam int VPK_NBUF = 2;

   // Bit 1: a frame is being filled. Bit 0: the buffer currently selected.
   typedef enum logic [1:0] {
      VPK_WAIT_0 = 2'b00,
      VPK_WAIT_1 = 2'b01,
      VPK_FILL_0 = 2'b10,
      VPK_FILL_1 = 2'b11
   } vpk_state_e;

   function automatic vpk_state_e vpk_state(input logic filling, input logic sel);
      return vpk_state_e'({filling, sel});
   endfunction

endpackage

// File: rtl/vpk_capture.sv
module vpk_capture #(
   parameter int DATA_W    = 16,
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_fv,
   input  logic              in_lv,
   output logic [DATA_W-1:0] cap_data,
   output logic              cap_fv,
   output logic              cap_lv
);

   generate
      if (FALL_EDGE) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_data <= '0;
               cap_fv   <= 1'b0;
               cap_lv   <= 1'b0;
            end else begin
               cap_data <= in_data;
               cap_fv   <= in_fv;
               cap_lv   <= in_lv;
            end
         end
      end else begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_data <= '0;
               cap_fv   <= 1'b0;
               cap_lv   <= 1'b0;
            end else begin
               cap_data <= in_data;
               cap_fv   <= in_fv;
               cap_lv   <= in_lv;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/vpk_owner.sv
module vpk_owner
   import vpk_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit,
   input  logic                commit_sel,
   input  logic                rel,
   input  logic                rel_sel,
   input  logic                ovf_set,
   input  logic                ovf_clr,
   output logic [VPK_NBUF-1:0] owned,
   output logic                overrun
);

   generate
      for (genvar b = 0; b < VPK_NBUF; b++) begin : g_buf
         logic take_b, give_b;
         assign take_b = commit & (commit_sel == 1'(b));
         assign give_b = rel & (rel_sel == 1'(b));
         // A commit in the same cycle as a release of the same buffer wins.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      owned[b] <= 1'b0;
            else if (take_b) owned[b] <= 1'b1;
            else if (give_b) owned[b] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overrun <= 1'b0;
      else        overrun <= ovf_set | (overrun & ~ovf_clr);
   end

   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !ovf_clr) |=> overrun);

   assert_ovf_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !ovf_set) |=> !overrun);

endmodule

// File: rtl/vpk_fill.sv
module vpk_fill
   import vpk_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 8184
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DATA_W-1:0]   cap_data,
   input  logic                cap_fv,
   input  logic                cap_lv,
   input  logic [VPK_NBUF-1:0] owned,
   output logic                wr_en,
   output logic                wr_sel,
   output logic [$clog2(BUF_WORDS)-1:0] wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                done_valid,
   output logic                done_sel,
   output logic [$clog2(BUF_WORDS*(DATA_W/8)+1)-1:0] done_bytes,
   output logic                done_eof,
   output logic                ovf_set
);

   localparam int BYTES = DATA_W / 8;
   localparam int AW    = $clog2(BUF_WORDS);
   localparam int BYW   = $clog2(BUF_WORDS * BYTES + 1);
   localparam logic [BYW-1:0] FULL_BYTES = BYW'(BUF_WORDS * BYTES);
   localparam logic [AW-1:0]  LAST_ADDR  = AW'(BUF_WORDS - 1);

   vpk_state_e    st_q;
   logic          fv_prev_q;
   logic [AW-1:0] cnt_q;

   logic fv_rise, fv_fall, cur_sel, filling, take, blocked, last_word;

   always_comb begin
      fv_rise   = cap_fv & ~fv_prev_q;
      fv_fall   = ~cap_fv & fv_prev_q;
      cur_sel   = st_q[0];
      filling   = st_q[1] | fv_rise;
      take      = filling & cap_fv & cap_lv;
      blocked   = owned[cur_sel];
      last_word = (cnt_q == LAST_ADDR);
   end

   assign ovf_set = take & blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= VPK_WAIT_0;
         fv_prev_q  <= 1'b1;      // a frame live at reset release is not a start
         cnt_q      <= '0;
         wr_en      <= 1'b0;
         wr_sel     <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         done_valid <= 1'b0;
         done_sel   <= 1'b0;
         done_bytes <= '0;
         done_eof   <= 1'b0;
      end else begin
         fv_prev_q  <= cap_fv;
         wr_en      <= take & ~blocked;
         done_valid <= 1'b0;
         done_eof   <= 1'b0;
         if (take && !blocked) begin
            wr_sel  <= cur_sel;
            wr_addr <= cnt_q;
            wr_data <= cap_data;
            if (last_word) begin
               done_valid <= 1'b1;
               done_sel   <= cur_sel;
               done_bytes <= FULL_BYTES;
               cnt_q      <= '0;
               st_q       <= vpk_state(1'b1, ~cur_sel);
            end else begin
               cnt_q <= cnt_q + 1'b1;
               st_q  <= vpk_state(1'b1, cur_sel);
            end
         end else if (st_q[1] && fv_fall) begin
            done_valid <= 1'b1;
            done_eof   <= 1'b1;
            done_sel   <= cur_sel;
            done_bytes <= BYW'(cnt_q) * BYW'(BYTES);
            cnt_q      <= '0;
            st_q       <= vpk_state(1'b0, (cnt_q != '0) ? ~cur_sel : cur_sel);
         end else if (fv_rise) begin
            st_q <= vpk_state(1'b1, cur_sel);
         end
      end
   end

   assert_full_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_eof) |-> (done_bytes == FULL_BYTES));

   assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en) && ($past(wr_sel) == wr_sel) && !$past(done_valid))
      |-> (wr_addr == $past(wr_addr) + 1'b1));

   assert_frame_end_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[1] && fv_fall) |=> (done_valid && done_eof));

endmodule

// File: rtl/vpk_packer.sv
module vpk_packer
   import vpk_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int BUF_WORDS = 8184,
   parameter bit FALL_EDGE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W-1:0]    pix_data,
   input  logic                 frame_vld,
   input  logic                 line_vld,
   input  logic                 ovf_clr,
   input  logic                 rel,
   input  logic                 rel_sel,
   output logic                 wr_en,
   output logic                 wr_sel,
   output logic [$clog2(BUF_WORDS)-1:0] wr_addr,
   output logic [DATA_W-1:0]    wr_data,
   output logic                 done_valid,
   output logic                 done_sel,
   output logic [$clog2(BUF_WORDS*(DATA_W/8)+1)-1:0] done_bytes,
   output logic                 done_eof,
   output logic                 overrun
);

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("vpk_packer: DATA_W must be a nonzero multiple of 8");
      end
      if (BUF_WORDS < 2) begin : g_bad_depth
         $error("vpk_packer: BUF_WORDS must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0]   cap_data;
   logic                cap_fv, cap_lv;
   logic [VPK_NBUF-1:0] owned;
   logic                ovf_set;

   vpk_capture #(.DATA_W(DATA_W), .FALL_EDGE(FALL_EDGE)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (pix_data),
      .in_fv    (frame_vld),
      .in_lv    (line_vld),
      .cap_data (cap_data),
      .cap_fv   (cap_fv),
      .cap_lv   (cap_lv)
   );

   vpk_fill #(.DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_data   (cap_data),
      .cap_fv     (cap_fv),
      .cap_lv     (cap_lv),
      .owned      (owned),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .done_valid (done_valid),
      .done_sel   (done_sel),
      .done_bytes (done_bytes),
      .done_eof   (done_eof),
      .ovf_set    (ovf_set)
   );

   vpk_owner u_own (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (done_valid && (done_bytes != '0)),
      .commit_sel (done_sel),
      .rel        (rel),
      .rel_sel    (rel_sel),
      .ovf_set    (ovf_set),
      .ovf_clr    (ovf_clr),
      .owned      (owned),
      .overrun    (overrun)
   );

   assert_no_write_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !owned[wr_sel]);

   assert_gated_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(cap_fv && cap_lv));

endmodule

// File: tb/tb_vpk_packer.sv
`timescale 1ns/1ps
module tb_vpk_packer;

   localparam int DW    = 16;
   localparam int BW    = 8;
   localparam int FULLB = BW * DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] pix_data = '0;
   logic frame_vld = 1'b0, line_vld = 1'b0, ovf_clr = 1'b0;
   logic rel_auto = 1'b0, rel_man = 1'b0, rsel_auto = 1'b0, rsel_man = 1'b0;
   logic rel, rel_sel;

   logic          wr_en, wr_sel, done_valid, done_sel, done_eof, overrun;
   logic [2:0]    wr_addr;
   logic [DW-1:0] wr_data;
   logic [4:0]    done_bytes;

   assign rel     = rel_auto | rel_man;
   assign rel_sel = rel_man ? rsel_man : rsel_auto;

   always #2.5 clk = ~clk;

   vpk_packer #(.DATA_W(DW), .BUF_WORDS(BW), .FALL_EDGE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .frame_vld(frame_vld),
      .line_vld(line_vld), .ovf_clr(ovf_clr), .rel(rel), .rel_sel(rel_sel),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .done_valid(done_valid), .done_sel(done_sel), .done_bytes(done_bytes),
      .done_eof(done_eof), .overrun(overrun)
   );

   // Counters: monitor-owned and stimulus-owned are kept apart.
   int mon_chk = 0, mon_fail = 0, st_chk = 0, st_fail = 0;
   int mon_wr = 0, mon_full = 0, mon_eof = 0, fw = 0, last_eof_bytes = 0;
   logic exp_sel = 1'b0;
   int cur_fn = 1;
   bit chk_wr = 1'b1, auto_rel = 1'b1, finished = 1'b0;

   function automatic logic [DW-1:0] pix(input int f, input int i);
      return DW'(f * 257 + i * 19 + 165);
   endfunction

   task automatic chk_mon(input bit ok, input string req, input string what,
                          input int act, input int exp);
      mon_chk++;
      if (!ok) begin
         mon_fail++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_st(input bit ok, input string req, input string what,
                         input int act, input int exp);
      st_chk++;
      if (!ok) begin
         st_fail++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Output monitor, sampled mid-cycle.
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            mon_wr++;
            if (chk_wr) begin
               chk_mon(wr_sel == exp_sel, "R2", "write buffer", int'(wr_sel), int'(exp_sel));
               chk_mon(int'(wr_addr) == fw % BW, "R2", "write address", int'(wr_addr), fw % BW);
               chk_mon(wr_data == pix(cur_fn, fw), "R1", "captured word",
                       int'(wr_data), int'(pix(cur_fn, fw)));
            end
            fw++;
         end
         if (done_valid) begin
            if (!done_eof) begin
               mon_full++;
               chk_mon(int'(done_bytes) == FULLB, "R3", "full commit bytes", int'(done_bytes), FULLB);
               chk_mon(done_sel == exp_sel, "R3", "full commit buffer", int'(done_sel), int'(exp_sel));
               chk_mon(wr_en && wr_addr == 3'(BW - 1), "R3", "commit with last word",
                       int'(wr_en), 1);
            end else begin
               mon_eof++;
               last_eof_bytes = int'(done_bytes);
               fw = 0;
            end
            if (done_bytes != '0) exp_sel = ~exp_sel;
         end
      end
   end

   // Automatic consumer: returns each handed-over buffer two cycles later.
   initial begin
      logic cs;
      forever begin
         @(negedge clk);
         if (rst_n && auto_rel && done_valid && done_bytes != '0) begin
            cs = done_sel;
            @(posedge clk); #1; rel_auto = 1'b1; rsel_auto = cs;
            @(posedge clk); #1; rel_auto = 1'b0;
         end
      end
   end

   task automatic drive(input logic f, input logic l, input logic [DW-1:0] d);
      @(posedge clk); #1;
      frame_vld = f; line_vld = l; pix_data = d;
   endtask

   task automatic run_frame(input int lines, input int px);
      int idx;
      idx = 0;
      drive(1'b1, 1'b0, 16'hBEEF);
      drive(1'b1, 1'b0, 16'hBEEF);
      for (int ln = 0; ln < lines; ln++) begin
         for (int p = 0; p < px; p++) begin
            drive(1'b1, 1'b1, pix(cur_fn, idx));
            idx++;
         end
         for (int b = 0; b < 3; b++) drive(1'b1, 1'b0, 16'hDEAD);
      end
      drive(1'b0, 1'b0, 16'hDEAD);
      drive(1'b0, 1'b1, 16'hFACE);   // line strobe outside a frame
      drive(1'b0, 1'b1, 16'hFACE);
      for (int b = 0; b < 5; b++) drive(1'b0, 1'b0, '0);
      cur_fn++;
   endtask

   task automatic rel_pulse(input logic s);
      @(posedge clk); #1; rel_man = 1'b1; rsel_man = s;
      @(posedge clk); #1; rel_man = 1'b0;
   endtask

   task automatic clr_pulse();
      @(posedge clk); #1; ovf_clr = 1'b1;
      @(posedge clk); #1; ovf_clr = 1'b0;
   endtask

   initial begin
      int w0, f0, e0, n;
      logic s;
      // R8: a frame already running while reset is held
      frame_vld = 1'b1; line_vld = 1'b1; pix_data = 16'h1234;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk_st(!wr_en, "R8", "wr_en after reset", int'(wr_en), 0);
      chk_st(!done_valid, "R8", "done_valid after reset", int'(done_valid), 0);
      chk_st(!overrun, "R8", "overrun after reset", int'(overrun), 0);
      w0 = mon_wr; e0 = mon_eof;
      for (int i = 0; i < 12; i++) drive(1'b1, (i % 4) != 3, DW'(i + 64));
      for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, '0);
      chk_st(mon_wr == w0, "R8", "writes from frame live at reset", mon_wr - w0, 0);
      chk_st(mon_eof == e0, "R8", "commits from frame live at reset", mon_eof - e0, 0);

      // Sweep of frame sizes crossing every buffer multiple (R1..R5)
      for (int lines = 1; lines <= 2; lines++) begin
         for (int px = 1; px <= 12; px++) begin
            n = lines * px;
            w0 = mon_wr; f0 = mon_full; e0 = mon_eof;
            run_frame(lines, px);
            chk_st(mon_wr - w0 == n, "R1", "accepted samples", mon_wr - w0, n);
            chk_st(mon_full - f0 == n / BW, "R3", "full commits", mon_full - f0, n / BW);
            chk_st(mon_eof - e0 == 1, "R4", "end-of-frame commits", mon_eof - e0, 1);
            if (n % BW != 0)
               chk_st(last_eof_bytes == 2 * (n % BW), "R4", "partial bytes",
                      last_eof_bytes, 2 * (n % BW));
            else
               chk_st(last_eof_bytes == 0, "R5", "end marker bytes", last_eof_bytes, 0);
         end
      end
      chk_st(!overrun, "R6", "no overrun with prompt releases", int'(overrun), 0);

      // R6/R7: consumer stops returning buffers
      s = exp_sel; auto_rel = 1'b0; chk_wr = 1'b0;
      w0 = mon_wr; f0 = mon_full;
      run_frame(1, 20);
      chk_st(mon_wr - w0 == 16, "R6", "writes before both held", mon_wr - w0, 16);
      chk_st(mon_full - f0 == 2, "R3", "full commits in overrun frame", mon_full - f0, 2);
      chk_st(overrun, "R6", "overrun raised", int'(overrun), 1);
      chk_st(last_eof_bytes == 0, "R5", "end marker after drops", last_eof_bytes, 0);
      for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, '0);
      chk_st(overrun, "R7", "overrun sticky", int'(overrun), 1);
      clr_pulse();
      @(negedge clk);
      chk_st(!overrun, "R7", "overrun cleared", int'(overrun), 0);

      w0 = mon_wr;
      run_frame(1, 3);
      chk_st(mon_wr == w0, "R6", "held buffer receives nothing", mon_wr - w0, 0);
      chk_st(overrun, "R6", "overrun on held buffer", int'(overrun), 1);
      rel_pulse(~s);
      w0 = mon_wr;
      run_frame(1, 2);
      chk_st(mon_wr == w0, "R6", "release of other buffer keeps hold", mon_wr - w0, 0);

      // R9: recovery after returning buffers
      rel_pulse(s);
      clr_pulse();
      @(negedge clk);
      chk_st(!overrun, "R7", "overrun cleared again", int'(overrun), 0);
      auto_rel = 1'b1; chk_wr = 1'b1;
      w0 = mon_wr; e0 = mon_eof;
      run_frame(1, 5);
      chk_st(mon_wr - w0 == 5, "R9", "writes after recovery", mon_wr - w0, 5);
      chk_st(last_eof_bytes == 10, "R9", "bytes after recovery", last_eof_bytes, 10);
      chk_st(mon_eof - e0 == 1, "R9", "commit after recovery", mon_eof - e0, 1);
      chk_st(!overrun, "R9", "no overrun after recovery", int'(overrun), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", st_chk + mon_chk - st_fail - mon_fail, st_chk + mon_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         $display("FAIL watchdog: run incomplete actual=0 expected=1");
         $display("%0d/%0d checks passed", st_chk + mon_chk - st_fail - mon_fail,
                  st_chk + mon_chk + 1);
         $finish;
      end
   end

endmodule